// File: doc/BRIEF.md
# I/Q Tensor Convolution Layer

This block is one convolution stage of a small neural classifier that looks at raw complex baseband. The host loads a window of I/Q samples into a sample store and a set of filter weights and biases into a parameter store, then pulses `start`. The layer folds the samples into a two-dimensional image, row by row. Horizontal neighbours in the image are one sample apart and vertical neighbours are `IMG_W` samples apart, so one kernel sees short transitions both within a row and across rows. Each image element has two channels, in-phase and quadrature, and every kernel covers both.

Each output is computed by one multiply-accumulate engine, one product per cycle. A per-filter bias is added, negative results are clamped to zero, and the value is rounded and saturated back to the data format. Results go into an internal FIFO that feeds a valid/ready stream to the next layer. The host can rewrite the parameter store between runs, which lets the same logic serve a different classification problem.

Top module: `iq_conv_layer`

## Requirements
- R1: Output (f, r, c) draws from samples whose store index is (r+kr)·IMG_W + (c+kc) for kernel row kr and kernel column kc. The sample written at address a is sample index a.
- R2: Parameters for filter f start at address f·(2·KER_H·KER_W+1). The weight for kernel row kr, column kc and channel ch sits at offset kr·2·KER_W + kc·2 + ch, where ch 0 multiplies the I part and ch 1 multiplies the Q part. The bias sits at offset 2·KER_H·KER_W.
- R3: Samples, weights, biases and outputs are 32-bit two's complement with 22 fraction bits. Products are summed exactly in an accumulator wide enough that no sum of one kernel's products plus bias can wrap.
- R4: An output equals sum + bias·2^22 taken at 44 fraction bits. If that value is negative the output is 0. Otherwise it is rounded to 22 fraction bits, with a half rounding upward, and saturated at 0x7FFFFFFF.
- R5: One run emits exactly (IMG_H−KER_H+1)·(IMG_W−KER_W+1)·NUM_FILT results, valid-mode with stride 1. They come out filter by filter, and inside one filter row by row, left to right.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` holds its value. Backpressure never loses or repeats a result.
- R7: Rewriting the parameter store between runs changes the results of the next run to match the new weights, with no other action.
- R8: `busy` goes high only in the cycle after a `start` pulse. A `start` pulse while `busy` is high has no effect.
- R9: After reset `m_valid` and `busy` are low.
- R10: With `m_ready` held low, the engine keeps computing until FIFO_DEPTH results are queued and then waits. It never overwrites a queued result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_we | input | 1 | Sample store write enable |
| smp_addr | input | SMP_AW | Sample index to write |
| smp_i | input | 32 | In-phase value, Q10.22 |
| smp_q | input | 32 | Quadrature value, Q10.22 |
| par_we | input | 1 | Parameter store write enable |
| par_addr | input | PAR_AW | Parameter address (layout in R2) |
| par_data | input | 32 | Weight or bias, Q10.22 |
| start | input | 1 | Begin one layer pass |
| busy | output | 1 | A pass is in progress |
| m_valid | output | 1 | Output stream valid |
| m_ready | input | 1 | Output stream ready |
| m_data | output | 32 | Output result, Q10.22 |

## Verification
The assertions assume that `m_ready` is the only thing that slows the output side. They also assume the host leaves both stores alone while `busy` is high, because the engine reads them combinationally during a pass. The stimulus writes samples and parameters only before pulsing `start` and after it has collected every result of the previous pass. It varies `m_ready` freely, including a long hold low that fills the FIFO. Its single illegal action is a second `start` in mid-pass, which the block must ignore.

// File: rtl/iq_conv_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the I/Q convolution layer.
// Assumes nothing beyond elaboration-time integer parameters.
package iq_conv_pkg;

    // Engine phases: waiting, accumulating taps, emitting one result
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_FIN  = 2'd2
    } eng_state_t;

    // Width helper that never returns zero
    function automatic int wmin1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/iq_tap_seq.sv
`timescale 1ns/1ps
// Tap and output-position sequencer.
// Walks channel (fastest), kernel column, kernel row for each output, and
// output column, output row, filter (slowest) across outputs. Produces the
// sample-store and parameter-store addresses for the current tap.
// Assumes the caller never asserts tap_step and out_step in the same cycle.
module iq_tap_seq
    import iq_conv_pkg::*;
#(
    parameter int IMG_W    = 8,
    parameter int IMG_H    = 4,
    parameter int KER_H    = 2,
    parameter int KER_W    = 4,
    parameter int NUM_FILT = 10,
    parameter int SMP_AW   = 5,
    parameter int PAR_AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tap_step,
    input  logic              out_step,
    output logic              ch,
    output logic              last_tap,
    output logic              last_out,
    output logic [SMP_AW-1:0] smp_addr,
    output logic [PAR_AW-1:0] w_addr,
    output logic [PAR_AW-1:0] b_addr
);
    localparam int OUT_H  = IMG_H - KER_H + 1;
    localparam int OUT_W  = IMG_W - KER_W + 1;
    localparam int TAPS   = 2 * KER_H * KER_W;
    localparam int PER_F  = TAPS + 1;
    localparam int KRW    = wmin1($clog2(KER_H));
    localparam int KCW    = wmin1($clog2(KER_W));
    localparam int ORW    = wmin1($clog2(OUT_H));
    localparam int OCW    = wmin1($clog2(OUT_W));
    localparam int OFW    = wmin1($clog2(NUM_FILT));

    logic [KRW-1:0] kr;
    logic [KCW-1:0] kc;
    logic [ORW-1:0] orow;
    logic [OCW-1:0] ocol;
    logic [OFW-1:0] filt;

    logic kc_end, kr_end, oc_end, or_end, of_end;
    assign kc_end = (kc == KCW'(KER_W - 1));
    assign kr_end = (kr == KRW'(KER_H - 1));
    assign oc_end = (ocol == OCW'(OUT_W - 1));
    assign or_end = (orow == ORW'(OUT_H - 1));
    assign of_end = (filt == OFW'(NUM_FILT - 1));

    assign last_tap = ch && kc_end && kr_end;
    assign last_out = oc_end && or_end && of_end;

    // Advance the tap counters within one kernel window
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ch <= 1'b0;
            kc <= '0;
            kr <= '0;
        end else if (tap_step) begin
            if (ch) begin
                ch <= 1'b0;
                if (kc_end) begin
                    kc <= '0;
                    kr <= kr_end ? '0 : kr + 1'b1;
                end else begin
                    kc <= kc + 1'b1;
                end
            end else begin
                ch <= 1'b1;
            end
        end
    end

    // Advance the output position: column, then row, then filter
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ocol <= '0;
            orow <= '0;
            filt <= '0;
        end else if (out_step) begin
            if (oc_end) begin
                ocol <= '0;
                if (or_end) begin
                    orow <= '0;
                    filt <= of_end ? '0 : filt + 1'b1;
                end else begin
                    orow <= orow + 1'b1;
                end
            end else begin
                ocol <= ocol + 1'b1;
            end
        end
    end

    // Row-major fold of the sample stream and parameter layout per filter
    always_comb begin
        int srow, scol, fbase;
        srow  = int'(orow) + int'(kr);
        scol  = int'(ocol) + int'(kc);
        fbase = int'(filt) * PER_F;
        smp_addr = SMP_AW'(srow * IMG_W + scol);
        w_addr   = PAR_AW'(fbase + int'(kr) * 2 * KER_W + int'(kc) * 2 + int'(ch));
        b_addr   = PAR_AW'(fbase + TAPS);
    end

endmodule

// File: rtl/iq_mac_unit.sv
`timescale 1ns/1ps
// Fixed-point multiply-accumulate with bias, ReLU, rounding and saturation.
// Products of two Q10.22 values are summed at 44 fraction bits in an
// accumulator sized so one kernel's sum plus bias cannot wrap.
// Assumes clr and add are never asserted together with intent to add.
module iq_mac_unit #(
    parameter int DW    = 32,
    parameter int FRAC  = 22,
    parameter int ACC_W = 70
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] w,
    input  logic [DW-1:0] bias,
    output logic [DW-1:0] result
);
    localparam logic signed [ACC_W-1:0] ROUND_C = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAX_POS =
        {{(ACC_W - DW + 1){1'b0}}, {(DW - 1){1'b1}}};

    logic signed [ACC_W-1:0] acc;
    logic signed [2*DW-1:0]  prod;
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] scaled;

    // Full-precision signed product of the current tap
    assign prod = $signed(x) * $signed(w);

    // Accumulate one product per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc <= '0;
        end else if (add) begin
            acc <= acc + ACC_W'(prod);
        end
    end

    // Add aligned bias, clamp negatives, round half up, saturate
    always_comb begin
        total  = acc + (ACC_W'($signed(bias)) <<< FRAC);
        scaled = (total + ROUND_C) >>> FRAC;
        if (total < 0) begin
            result = '0;
        end else if (scaled > MAX_POS) begin
            result = MAX_POS[DW-1:0];
        end else begin
            result = scaled[DW-1:0];
        end
    end

endmodule

// File: rtl/iq_stream_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO with a valid/ready read side.
// Assumes the writer pushes only when full is low.
module iq_stream_fifo
    import iq_conv_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    output logic          full,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] dout
);
    localparam int PW = wmin1($clog2(DEPTH));
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          pop;

    assign full      = (count == CW'(DEPTH));
    assign out_valid = (count != '0);
    assign pop       = out_valid && out_ready;
    assign dout      = store[rd_ptr];

    // Write the incoming result into the slot at the write pointer
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= din;
        end
    end

    // Maintain pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

endmodule

// File: rtl/iq_conv_layer.sv
`timescale 1ns/1ps
// Convolution layer over an I/Q sample window folded into a 2-channel image.
// Holds a sample store and a parameter store written by the host, runs one
// tap per cycle through a single MAC, and queues results in an output FIFO.
// Assumes the host does not write either store while busy is high.
module iq_conv_layer
    import iq_conv_pkg::*;
#(
    parameter int IMG_W      = 8,
    parameter int IMG_H      = 4,
    parameter int KER_H      = 2,
    parameter int KER_W      = 4,
    parameter int NUM_FILT   = 10,
    parameter int DATA_W     = 32,
    parameter int FRAC_W     = 22,
    parameter int FIFO_DEPTH = 8,
    localparam int SAMPLES   = IMG_W * IMG_H,
    localparam int TAPS      = 2 * KER_H * KER_W,
    localparam int NPAR      = NUM_FILT * (TAPS + 1),
    localparam int SMP_AW    = wmin1($clog2(SAMPLES)),
    localparam int PAR_AW    = wmin1($clog2(NPAR))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_we,
    input  logic [SMP_AW-1:0] smp_addr,
    input  logic [DATA_W-1:0] smp_i,
    input  logic [DATA_W-1:0] smp_q,
    input  logic              par_we,
    input  logic [PAR_AW-1:0] par_addr,
    input  logic [DATA_W-1:0] par_data,
    input  logic              start,
    output logic              busy,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data
);
    localparam int ACC_W = 2 * DATA_W + $clog2(TAPS + 1) + 1;

    logic [DATA_W-1:0] i_mem [SAMPLES];
    logic [DATA_W-1:0] q_mem [SAMPLES];
    logic [DATA_W-1:0] p_mem [NPAR];

    eng_state_t        state;
    logic              seq_clr, tap_step, out_step;
    logic              cur_ch, last_tap, last_out;
    logic [SMP_AW-1:0] rd_smp;
    logic [PAR_AW-1:0] rd_w, rd_b;
    logic [DATA_W-1:0] tap_x, result;
    logic              mac_clr, fifo_push, fifo_full;

    // Host writes into the sample store
    always_ff @(posedge clk) begin
        if (smp_we) begin
            i_mem[smp_addr] <= smp_i;
            q_mem[smp_addr] <= smp_q;
        end
    end

    // Host writes into the parameter store
    always_ff @(posedge clk) begin
        if (par_we) begin
            p_mem[par_addr] <= par_data;
        end
    end

    // Engine phase control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start)     state <= ST_MAC;
                ST_MAC:  if (last_tap)  state <= ST_FIN;
                ST_FIN:  if (fifo_push) state <= last_out ? ST_IDLE : ST_MAC;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-phase strobes
    always_comb begin
        seq_clr   = (state == ST_IDLE) && start;
        tap_step  = (state == ST_MAC);
        fifo_push = (state == ST_FIN) && !fifo_full;
        out_step  = fifo_push;
        mac_clr   = seq_clr || fifo_push;
        busy      = (state != ST_IDLE);
    end

    // Channel select: 0 feeds I, 1 feeds Q
    assign tap_x = cur_ch ? q_mem[rd_smp] : i_mem[rd_smp];

    iq_tap_seq #(
        .IMG_W    (IMG_W),
        .IMG_H    (IMG_H),
        .KER_H    (KER_H),
        .KER_W    (KER_W),
        .NUM_FILT (NUM_FILT),
        .SMP_AW   (SMP_AW),
        .PAR_AW   (PAR_AW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (seq_clr),
        .tap_step (tap_step),
        .out_step (out_step),
        .ch       (cur_ch),
        .last_tap (last_tap),
        .last_out (last_out),
        .smp_addr (rd_smp),
        .w_addr   (rd_w),
        .b_addr   (rd_b)
    );

    iq_mac_unit #(
        .DW    (DATA_W),
        .FRAC  (FRAC_W),
        .ACC_W (ACC_W)
    ) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (mac_clr),
        .add    (tap_step),
        .x      (tap_x),
        .w      (p_mem[rd_w]),
        .bias   (p_mem[rd_b]),
        .result (result)
    );

    iq_stream_fifo #(
        .DW    (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .din       (result),
        .full      (fifo_full),
        .out_valid (m_valid),
        .out_ready (m_ready),
        .dout      (m_data)
    );

endmodule

// File: rtl/iq_conv_layer_chk.sv
`timescale 1ns/1ps
// Protocol and safety properties for the convolution layer, bound to the top.
// Assumes m_ready is the only back-pressure and stores are static while busy.
module iq_conv_layer_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          m_valid,
    input logic          m_ready,
    input logic [DW-1:0] m_data,
    input logic          fifo_push,
    input logic          fifo_full
);
    // R6: a stalled beat stays offered
    a_r6_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid);

    // R6: a stalled beat keeps its value
    a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> $stable(m_data));

    // R4: results are never negative after the clamp
    a_r4_non_negative: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !m_data[DW-1]);

    // R10: no result is written into a full queue
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    // R8: a pass begins only after a start request
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

bind iq_conv_layer iq_conv_layer_chk #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_data    (m_data),
    .fifo_push (fifo_push),
    .fifo_full (fifo_full)
);

// File: tb/iq_conv_layer_test.sv
`timescale 1ns/1ps
// Directed bench for the I/Q convolution layer, one task per scenario.
module iq_conv_layer_test;
    localparam int IW = 8, IH = 4, KH = 2, KW = 4, NF = 10, FD = 8;
    localparam int NS   = IW * IH;
    localparam int TP   = 2 * KH * KW;
    localparam int PF   = TP + 1;
    localparam int NP   = NF * PF;
    localparam int OH   = IH - KH + 1;
    localparam int OW   = IW - KW + 1;
    localparam int NOUT = OH * OW * NF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_we, par_we, start, m_ready;
    logic [4:0]  smp_addr;
    logic [7:0]  par_addr;
    logic [31:0] smp_i, smp_q, par_data;
    logic        busy, m_valid;
    logic [31:0] m_data;

    int checks = 0;
    int errors = 0;
    logic [31:0] lcg = 32'h1234_5678;
    longint bi [NS];
    longint bq [NS];
    longint bp [NP];
    logic [31:0] got  [NOUT];
    logic [31:0] prev [NOUT];

    always #2.5 clk = ~clk;

    iq_conv_layer #(
        .IMG_W(IW), .IMG_H(IH), .KER_H(KH), .KER_W(KW),
        .NUM_FILT(NF), .FIFO_DEPTH(FD)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .smp_we(smp_we), .smp_addr(smp_addr), .smp_i(smp_i), .smp_q(smp_q),
        .par_we(par_we), .par_addr(par_addr), .par_data(par_data),
        .start(start), .busy(busy),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Value in roughly +/-1.0 in Q10.22
    function automatic longint small_val();
        logic [31:0] r;
        r = next_rand();
        return longint'($signed(r)) >>> 9;
    endfunction

    function automatic int paddr(input int f, input int kr, input int kc, input int ch);
        return f * PF + kr * 2 * KW + kc * 2 + ch;
    endfunction

    // Independent model of one output from the requirements
    function automatic logic [31:0] model(input int k);
        int f, r, c;
        longint acc, rnd;
        f = k / (OH * OW);
        r = (k / OW) % OH;
        c = k % OW;
        acc = 0;
        for (int kr = 0; kr < KH; kr++)
            for (int kc = 0; kc < KW; kc++) begin
                int s;
                s = (r + kr) * IW + (c + kc);
                acc += bi[s] * bp[paddr(f, kr, kc, 0)];
                acc += bq[s] * bp[paddr(f, kr, kc, 1)];
            end
        acc += bp[f * PF + TP] <<< 22;
        if (acc < 0) return 32'd0;
        rnd = (acc + (longint'(1) <<< 21)) >>> 22;
        if (rnd > 64'sh7FFF_FFFF) return 32'h7FFF_FFFF;
        return rnd[31:0];
    endfunction

    task automatic wr_smp(input int a, input longint vi, input longint vq);
        @(negedge clk);
        smp_we = 1'b1; smp_addr = 5'(a); smp_i = vi[31:0]; smp_q = vq[31:0];
        bi[a] = longint'($signed(vi[31:0]));
        bq[a] = longint'($signed(vq[31:0]));
        @(negedge clk);
        smp_we = 1'b0;
    endtask

    task automatic wr_par(input int a, input longint v);
        @(negedge clk);
        par_we = 1'b1; par_addr = 8'(a); par_data = v[31:0];
        bp[a] = longint'($signed(v[31:0]));
        @(negedge clk);
        par_we = 1'b0;
    endtask

    task automatic load_random_samples();
        for (int a = 0; a < NS; a++) wr_smp(a, small_val(), small_val());
    endtask

    task automatic load_random_params();
        for (int a = 0; a < NP; a++) wr_par(a, small_val());
    endtask

    // Start a pass, collect every beat under a ready pattern and compare.
    // mode 0: ready high; 1: ready low one cycle in three; 2: ready low 400 cycles
    task automatic run_layer(input int mode, input bit extra_start, input string req);
        int n = 0;
        int cyc = 0;
        int extra = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n < NOUT && cyc < 20000) begin
            if (mode == 2 && cyc == 399) begin
                chk(m_valid && busy, "R10", "queue full and engine waiting",
                    {m_valid, busy}, 2'b11);
            end
            case (mode)
                1:       m_ready = (cyc % 3 != 1);
                2:       m_ready = (cyc >= 400);
                default: m_ready = 1'b1;
            endcase
            start = (extra_start && (cyc == 20 || cyc == 21));
            if (m_valid && m_ready) begin
                logic [31:0] e;
                e = model(n);
                got[n] = m_data;
                chk(m_data == e, req, $sformatf("beat %0d", n), m_data, e);
                n++;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(n == NOUT, "R5", "beat count", n, NOUT);
        m_ready = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (m_valid) extra++;
            @(negedge clk);
        end
        chk(extra == 0, extra_start ? "R8" : "R5", "beats after pass", extra, 0);
        chk(busy == 1'b0, "R8", "busy after pass", busy, 0);
    endtask

    task automatic test_reset();
        chk(m_valid == 1'b0, "R9", "m_valid in reset", m_valid, 0);
        chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
    endtask

    task automatic test_basic();
        load_random_samples();
        load_random_params();
        run_layer(0, 1'b0, "R1 R3 R5");
    endtask

    task automatic test_stall();
        run_layer(1, 1'b0, "R6");
    endtask

    task automatic test_backpressure();
        run_layer(2, 1'b0, "R10");
    endtask

    task automatic test_restart_ignored();
        run_layer(0, 1'b1, "R8");
        for (int k = 0; k < NOUT; k++) prev[k] = got[k];
    endtask

    task automatic test_reconfig();
        int diff = 0;
        load_random_params();
        run_layer(0, 1'b0, "R7");
        for (int k = 0; k < NOUT; k++) if (got[k] != prev[k]) diff++;
        chk(diff > 0, "R7", "outputs changed after rewrite", diff, 1);
    endtask

    // Only the Q weight at kernel row 1, column 2 of filter 0 is 1.0
    task automatic test_channel();
        for (int a = 0; a < NS; a++) wr_smp(a, -longint'(a + 1) <<< 22, a * 1000 + 7);
        for (int a = 0; a < NP; a++) wr_par(a, 0);
        wr_par(paddr(0, 1, 2, 1), longint'(1) <<< 22);
        run_layer(0, 1'b0, "R2");
        for (int r = 0; r < OH; r++)
            for (int c = 0; c < OW; c++) begin
                longint e;
                e = ((r + 1) * IW + (c + 2)) * 1000 + 7;
                chk(got[r * OW + c] == e[31:0], "R1 R2",
                    $sformatf("Q tap pick r%0d c%0d", r, c), got[r * OW + c], e);
            end
    endtask

    // Single I tap per filter to probe rounding, saturation and the clamp
    task automatic test_round_sat();
        for (int a = 0; a < NS; a++) wr_smp(a, small_val(), small_val());
        wr_smp(0, 1, 0);
        wr_smp(1, 32'sh4000_0000, 0);
        wr_smp(2, -5, 0);
        wr_smp(3, 3, 0);
        for (int a = 0; a < NP; a++) wr_par(a, 0);
        wr_par(paddr(0, 0, 0, 0), longint'(1) <<< 21);
        wr_par(paddr(1, 0, 0, 0), 32'sh4000_0000);
        wr_par(paddr(2, 0, 0, 0), longint'(1) <<< 22);
        wr_par(2 * PF + TP, -64'sd2147483648);
        for (int f = 3; f < NF; f++) wr_par(paddr(f, 0, 0, 0), longint'(1) <<< 22);
        run_layer(0, 1'b0, "R4");
        chk(got[0] == 32'd1, "R4", "half ulp rounds up", got[0], 1);
        chk(got[3] == 32'd2, "R4", "1.5 ulp rounds up", got[3], 2);
        chk(got[OH * OW + 1] == 32'h7FFF_FFFF, "R4", "saturation",
            got[OH * OW + 1], 64'h7FFF_FFFF);
        chk(got[2 * OH * OW] == 32'd0, "R4", "negative clamps to zero",
            got[2 * OH * OW], 0);
        chk(got[3 * OH * OW + 2] == 32'd0, "R4", "negative sample clamps",
            got[3 * OH * OW + 2], 0);
        chk(got[3 * OH * OW + 3] == 32'd3, "R3", "unity weight passes value",
            got[3 * OH * OW + 3], 3);
    endtask

    initial begin
        #(5.0 * 150000);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        smp_we = 1'b0; par_we = 1'b0; start = 1'b0; m_ready = 1'b0;
        smp_addr = '0; par_addr = '0; smp_i = '0; smp_q = '0; par_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_stall();
        test_backpressure();
        test_restart_ignored();
        test_reconfig();
        test_channel();
        test_round_sat();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule